// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block watches a bank of level-sensitive interrupt request lines and decides, every cycle, whether a processor core should leave the handler it is running for a more urgent one. Each line has its own enable bit, pending bit and priority value. Software reaches all of them through a small word-wide register port. A lower priority number means a more urgent line. A software-chosen split divides every priority into an upper group part and a lower subpriority part. Only the group part can cause preemption. The full value, and after it the line index, chooses among pending lines.

The core accepts a preemption offer with `take_i`. The controller then holds an entry window of fixed length. During that window a request with a strictly more urgent group replaces the chosen line. At the end of the window the chosen line is committed: its pending bit clears, its group goes onto an active-level stack, and the handler address is available. The address is the software-set table base plus four times the exception number (16 plus the line index). When the core signals handler return with `eoi_i`, the stack pops. If a pending line beats the level below the returning handler, entry to that line starts at once, with no stop at the interrupted level.

Top module: `nest_irq_ctrl`

## Requirements
- R1: The register port decodes word addresses as follows. 0 sets enable bits, 1 clears enable bits; both read back the enable mask. 2 sets pending bits, 3 clears pending bits; both read back the pending mask. 4 holds the subpriority width S in bits [1:0]. 5 holds the table base; bits [6:0] read as zero. 8+i holds the priority of line i in bits [2:0]. Any other address reads zero. A write takes effect on the next cycle, and a read returns the current value in the same cycle.
- R2: A line's pending bit sets on the cycle after its request is high while the line is not on the active stack. It clears on the cycle after its entry commits. A request still high after its handler returns makes the line pending again one cycle after the return. A clear in a cycle overrides a set in the same cycle.
- R3: The winner is the enabled, pending line with the numerically smallest full priority. Among equal full priorities, the lowest line index wins. A disabled line never wins.
- R4: The group of a priority p is p with its low S bits forced to zero. `preempt_o` is high only when no entry is in progress, the stack is not full, and the winner's group is strictly below the active level. The idle level is 8.
- R5: `take_i` while `preempt_o` is high starts an entry. `entering_o` is then high for exactly 3 cycles, and `commit_o` is high in the last of them. While `entering_o` is high, `handler_id_o` holds the chosen line and `vec_addr_o` equals base + 4×(16 + line). `take_i` has no effect when `preempt_o` is low or when `eoi_i` is also high.
- R6: In the first two cycles of an entry, a winner whose group is strictly more urgent than the chosen line's group replaces it, and `late_arrival_o` pulses in that cycle. The entry window is not restarted.
- R7: A commit pushes the chosen line's group, and `active_lvl_o` shows it from the next cycle on. `eoi_i` outside an entry, with a non-empty stack, pops one level. `active_lvl_o` shows the top entry, or 8 when the stack is empty.
- R8: At a pop, if the winner's group is strictly more urgent than the level left after the pop, `tail_chain_o` pulses and an entry for the winner starts in the next cycle without `take_i`.
- R9: With 4 levels on the stack no preemption is offered. `eoi_i` during an entry or with an empty stack has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | N_IRQ | Level-sensitive request lines |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | RA_W | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| take_i | input | 1 | Core accepts the preemption offer |
| eoi_i | input | 1 | Core returns from the current handler |
| preempt_o | output | 1 | A pending line should preempt now |
| entering_o | output | 1 | Entry window in progress |
| handler_id_o | output | log2(N_IRQ) | Line being entered |
| vec_addr_o | output | 32 | Handler address of the line being entered |
| commit_o | output | 1 | Entry completes this cycle |
| late_arrival_o | output | 1 | Entry target replaced this cycle |
| tail_chain_o | output | 1 | Return goes straight to a new entry |
| active_lvl_o | output | PRIO_W+1 | Current active group level, 8 when idle |

## Verification
The hardest situations to reach are a late arrival inside the short entry window and a tail-chain that must beat the level under the returning handler, not the returning handler itself. The stimulus raises a more urgent request on the cycle right after `take_i`, so that its pending bit lands inside the window. It leaves two lines latched pending while nested handlers return one by one, so that one pop chains and the next does not. A further sequence nests four handlers, so that a more urgent request then meets a full stack.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int unsigned EXC_OFFSET = 16;

  // Base is aligned down to 128 bytes; one 4-byte slot per exception number.
  function automatic logic [31:0] handler_addr(input logic [31:0] base, input logic [7:0] line);
    logic [31:0] slot;
    slot = ({24'd0, line} + EXC_OFFSET) << 2;
    return {base[31:7], 7'd0} + slot;
  endfunction

  // Preemption group: the low `sub` bits of the priority are dropped.
  function automatic logic [7:0] group_of(input logic [7:0] prio, input logic [3:0] sub);
    logic [7:0] keep;
    keep = 8'hFF << sub;
    return prio & keep;
  endfunction
endpackage

// File: rtl/nic_regs.sv
module nic_regs #(
  parameter int N    = 8,
  parameter int PW   = 3,
  parameter int SUBW = 2,
  parameter int RA_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [RA_W-1:0]      addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  input  logic [N-1:0]         irq,
  input  logic [N-1:0]         active,
  input  logic                 commit,
  input  logic [$clog2(N)-1:0] commit_id,
  output logic [N-1:0]         en,
  output logic [N-1:0]         pend,
  output logic [N-1:0][PW-1:0] prio,
  output logic [SUBW-1:0]      sub,
  output logic [31:0]          vbase
);
  localparam logic [RA_W-1:0] A_EN_SET = RA_W'(0);
  localparam logic [RA_W-1:0] A_EN_CLR = RA_W'(1);
  localparam logic [RA_W-1:0] A_PD_SET = RA_W'(2);
  localparam logic [RA_W-1:0] A_PD_CLR = RA_W'(3);
  localparam logic [RA_W-1:0] A_GROUP  = RA_W'(4);
  localparam logic [RA_W-1:0] A_VBASE  = RA_W'(5);
  localparam int              A_PRIO0  = 8;

  logic [N-1:0] pd_set_m, pd_clr_m, pend_nxt, commit_m;

  assign commit_m = commit ? ({{(N-1){1'b0}}, 1'b1} << commit_id) : '0;
  assign pd_set_m = ((we && addr == A_PD_SET) ? wdata[N-1:0] : '0) | (irq & ~active);
  assign pd_clr_m = ((we && addr == A_PD_CLR) ? wdata[N-1:0] : '0) | commit_m;
  assign pend_nxt = (pend | pd_set_m) & ~pd_clr_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= '0;
      pend  <= '0;
      prio  <= '0;
      sub   <= '0;
      vbase <= '0;
    end else begin
      pend <= pend_nxt;
      if (we && addr == A_EN_SET) en <= en | wdata[N-1:0];
      if (we && addr == A_EN_CLR) en <= en & ~wdata[N-1:0];
      if (we && addr == A_GROUP)  sub <= wdata[SUBW-1:0];
      if (we && addr == A_VBASE)  vbase <= {wdata[31:7], 7'd0};
      for (int i = 0; i < N; i++)
        if (we && addr == RA_W'(A_PRIO0 + i)) prio[i] <= wdata[PW-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_EN_SET, A_EN_CLR: rdata[N-1:0] = en;
      A_PD_SET, A_PD_CLR: rdata[N-1:0] = pend;
      A_GROUP:            rdata[SUBW-1:0] = sub;
      A_VBASE:            rdata = vbase;
      default:
        for (int i = 0; i < N; i++)
          if (addr == RA_W'(A_PRIO0 + i)) rdata[PW-1:0] = prio[i];
    endcase
  end

  // R2
  commit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !(we && addr == A_PD_SET) |=> !pend[$past(commit_id)]);
endmodule

// File: rtl/nic_pick.sv
module nic_pick #(
  parameter int N    = 8,
  parameter int PW   = 3,
  parameter int SUBW = 2
) (
  input  logic [N-1:0]         en,
  input  logic [N-1:0]         pend,
  input  logic [N-1:0][PW-1:0] prio,
  input  logic [SUBW-1:0]      sub,
  output logic                 win_valid,
  output logic [$clog2(N)-1:0] win_id,
  output logic [PW:0]          win_grp
);
  localparam int IDW = $clog2(N);
  logic [PW-1:0] best;

  // Ascending scan with strict compare: equal values keep the lower index.
  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    best      = '1;
    for (int i = 0; i < N; i++) begin
      if (en[i] && pend[i] && (!win_valid || prio[i] < best)) begin
        win_valid = 1'b1;
        win_id    = IDW'(i);
        best      = prio[i];
      end
    end
    win_grp = {1'b0, PW'(nic_pkg::group_of(8'(best), 4'(sub)))};
  end
endmodule

// File: rtl/nic_stack.sv
module nic_stack #(
  parameter int N     = 8,
  parameter int DEPTH = 4,
  parameter int PW    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push,
  input  logic [$clog2(N)-1:0] push_id,
  input  logic [PW-1:0]        push_grp,
  input  logic                 pop,
  output logic [PW:0]          top_lvl,
  output logic [PW:0]          below_lvl,
  output logic                 full,
  output logic                 empty,
  output logic [N-1:0]         active
);
  localparam int          IDW  = $clog2(N);
  localparam int          IW   = $clog2(DEPTH);
  localparam int          SPW  = $clog2(DEPTH + 1);
  localparam logic [PW:0] IDLE = {1'b1, {PW{1'b0}}};

  logic [IDW-1:0] sid  [DEPTH];
  logic [PW-1:0]  sgrp [DEPTH];
  logic [SPW-1:0] sp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp <= '0;
      for (int j = 0; j < DEPTH; j++) begin
        sid[j]  <= '0;
        sgrp[j] <= '0;
      end
    end else if (push) begin
      sid[IW'(sp)]  <= push_id;
      sgrp[IW'(sp)] <= push_grp;
      sp <= sp + 1'b1;
    end else if (pop) begin
      sp <= sp - 1'b1;
    end
  end

  assign full      = (sp == SPW'(DEPTH));
  assign empty     = (sp == '0);
  assign top_lvl   = empty ? IDLE : {1'b0, sgrp[IW'(sp - 1'b1)]};
  assign below_lvl = (sp >= SPW'(2)) ? {1'b0, sgrp[IW'(sp - SPW'(2))]} : IDLE;

  for (genvar i = 0; i < N; i++) begin : g_act
    always_comb begin
      active[i] = 1'b0;
      for (int j = 0; j < DEPTH; j++)
        if (SPW'(j) < sp && sid[j] == IDW'(i)) active[i] = 1'b1;
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
  // R7
  pop_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push |=> sp == $past(sp) - 1'b1);
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int N_IRQ     = 8,
  parameter int PRIO_W    = 3,
  parameter int DEPTH     = 4,
  parameter int ENTRY_CYC = 3,
  parameter int RA_W      = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_IRQ-1:0]         irq_i,
  input  logic                     reg_we_i,
  input  logic [RA_W-1:0]          reg_addr_i,
  input  logic [31:0]              reg_wdata_i,
  output logic [31:0]              reg_rdata_o,
  input  logic                     take_i,
  input  logic                     eoi_i,
  output logic                     preempt_o,
  output logic                     entering_o,
  output logic [$clog2(N_IRQ)-1:0] handler_id_o,
  output logic [31:0]              vec_addr_o,
  output logic                     commit_o,
  output logic                     late_arrival_o,
  output logic                     tail_chain_o,
  output logic [PRIO_W:0]          active_lvl_o
);
  localparam int IDW  = $clog2(N_IRQ);
  localparam int SUBW = $clog2(PRIO_W + 1);
  localparam int CW   = $clog2(ENTRY_CYC);

  logic [N_IRQ-1:0]             en, pend, line_active;
  logic [N_IRQ-1:0][PRIO_W-1:0] prio;
  logic [SUBW-1:0]              sub;
  logic [31:0]                  vbase;
  logic                         win_valid, stk_full, stk_empty;
  logic [IDW-1:0]               win_id, cand_id;
  logic [PRIO_W:0]              win_grp, top_lvl, below_lvl, cand_grp;
  logic [CW-1:0]                cnt;
  logic                         entering;
  logic                         do_take, do_pop, do_tail, do_late, do_commit;

  nic_regs #(.N(N_IRQ), .PW(PRIO_W), .SUBW(SUBW), .RA_W(RA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we_i), .addr(reg_addr_i), .wdata(reg_wdata_i),
    .rdata(reg_rdata_o), .irq(irq_i), .active(line_active), .commit(do_commit),
    .commit_id(cand_id), .en(en), .pend(pend), .prio(prio), .sub(sub), .vbase(vbase));

  nic_pick #(.N(N_IRQ), .PW(PRIO_W), .SUBW(SUBW)) u_pick (
    .en(en), .pend(pend), .prio(prio), .sub(sub),
    .win_valid(win_valid), .win_id(win_id), .win_grp(win_grp));

  nic_stack #(.N(N_IRQ), .DEPTH(DEPTH), .PW(PRIO_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(do_commit), .push_id(cand_id),
    .push_grp(cand_grp[PRIO_W-1:0]), .pop(do_pop), .top_lvl(top_lvl),
    .below_lvl(below_lvl), .full(stk_full), .empty(stk_empty), .active(line_active));

  // Named decision events.
  assign preempt_o = !entering && win_valid && (win_grp < top_lvl) && !stk_full;
  assign do_take   = !entering && !eoi_i && take_i && preempt_o;
  assign do_pop    = !entering && eoi_i && !stk_empty;
  assign do_tail   = do_pop && win_valid && (win_grp < below_lvl);
  assign do_late   = entering && (cnt != '0) && win_valid && (win_grp < cand_grp);
  assign do_commit = entering && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entering <= 1'b0;
      cand_id  <= '0;
      cand_grp <= '0;
      cnt      <= '0;
    end else if (do_take || do_tail) begin
      entering <= 1'b1;
      cand_id  <= win_id;
      cand_grp <= win_grp;
      cnt      <= CW'(ENTRY_CYC - 1);
    end else if (entering) begin
      if (do_late) begin
        cand_id  <= win_id;
        cand_grp <= win_grp;
      end
      if (do_commit) entering <= 1'b0;
      else cnt <= cnt - 1'b1;
    end
  end

  assign entering_o     = entering;
  assign handler_id_o   = cand_id;
  assign vec_addr_o     = nic_pkg::handler_addr(vbase, 8'(cand_id));
  assign commit_o       = do_commit;
  assign late_arrival_o = do_late;
  assign tail_chain_o   = do_tail;
  assign active_lvl_o   = top_lvl;

  // R6
  late_urgency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_late |=> cand_grp < $past(cand_grp));
  // R7
  commit_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_commit |=> active_lvl_o == $past(cand_grp));
  // R5
  commit_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_commit |=> !entering_o);
  // R8
  tail_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_tail |=> entering_o && handler_id_o == $past(win_id));
endmodule

// File: tb/sim_nest_irq_ctrl.sv
module sim_nest_irq_ctrl;
  localparam int CLK_P = 10;
  localparam int N = 8, PW = 3, D = 4, EC = 3, RA = 5, IDLE = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] irq = '0;
  logic we = 0, take = 0, eoi = 0;
  logic [RA-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata, vaddr;
  logic preempt, entering, commit, late, tail;
  logic [2:0] hid;
  logic [PW:0] lvl;

  always #(CLK_P/2) clk = ~clk;

  nest_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .take_i(take), .eoi_i(eoi),
    .preempt_o(preempt), .entering_o(entering), .handler_id_o(hid), .vec_addr_o(vaddr),
    .commit_o(commit), .late_arrival_o(late), .tail_chain_o(tail), .active_lvl_o(lvl));

  int vecs = 0, bad = 0;
  bit done = 0;

  // Behavioural reference state
  bit m_en[N], m_pend[N];
  int m_prio[N];
  int m_sub = 0;
  logic [31:0] m_base = '0;
  int stk_id[$], stk_grp[$];
  bit m_ent = 0;
  int m_cand = 0, m_cgrp = 0, m_cnt = 0;
  // Derived per-cycle decisions
  bit e_wv, e_pre, e_take, e_pop, e_tail, e_late, e_commit;
  int e_wid, e_wg;
  int want_id = -1;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int grp(int p);
    return p & ~((1 << m_sub) - 1);
  endfunction

  function automatic int level_at(int depth_from_top);
    if (stk_grp.size() <= depth_from_top) return IDLE;
    return stk_grp[stk_grp.size() - 1 - depth_from_top];
  endfunction

  function automatic bit on_stack(int i);
    foreach (stk_id[k]) if (stk_id[k] == i) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] read_model(int a);
    logic [31:0] r = '0;
    if (a <= 3) for (int i = 0; i < N; i++) r[i] = (a < 2) ? m_en[i] : m_pend[i];
    else if (a == 4) r = m_sub;
    else if (a == 5) r = m_base;
    else if (a >= 8 && a < 8 + N) r = m_prio[a-8];
    return r;
  endfunction

  function automatic void derive();
    int best = 1000;
    e_wv = 0; e_wid = 0;
    for (int i = 0; i < N; i++)
      if (m_en[i] && m_pend[i] && m_prio[i] < best) begin
        best = m_prio[i]; e_wid = i; e_wv = 1;
      end
    e_wg = e_wv ? grp(best) : IDLE;
    e_pre    = !m_ent && e_wv && e_wg < level_at(0) && stk_grp.size() < D;
    e_take   = !m_ent && !eoi && take && e_pre;
    e_pop    = !m_ent && eoi && stk_grp.size() > 0;
    e_tail   = e_pop && e_wv && e_wg < level_at(1);
    e_late   = m_ent && m_cnt != 0 && e_wv && e_wg < m_cgrp;
    e_commit = m_ent && m_cnt == 0;
  endfunction

  task automatic compare();
    derive();
    check(stk_grp.size() == D ? "R9 full stack preempt" : "R4 preempt", preempt, e_pre);
    check("R7 active level", lvl, level_at(0));
    check("R5 entering", entering, m_ent);
    check("R5 commit", commit, e_commit);
    check("R6 late arrival", late, e_late);
    check("R8 tail chain", tail, e_tail);
    check((addr == 2 || addr == 3) ? "R2 pending read" : "R1 register read", rdata, read_model(int'(addr)));
    if (m_ent) begin
      check("R3 handler id", hid, m_cand);
      check("R5 vector address", vaddr, m_base + 32'(4 * (16 + m_cand)));
    end
    if (want_id >= 0) begin
      check("R3 directed winner", hid, want_id);
      want_id = -1;
    end
  endtask

  task automatic update();
    bit act[N];
    for (int i = 0; i < N; i++) act[i] = on_stack(i);
    for (int i = 0; i < N; i++) begin
      bit p = m_pend[i] | (we && addr == 2 && wdata[i]) | (irq[i] && !act[i]);
      if (we && addr == 3 && wdata[i]) p = 0;
      if (e_commit && m_cand == i) p = 0;
      m_pend[i] = p;
      if (we && addr == 0 && wdata[i]) m_en[i] = 1;
      if (we && addr == 1 && wdata[i]) m_en[i] = 0;
      if (we && addr == 8 + i) m_prio[i] = wdata[PW-1:0];
    end
    if (we && addr == 4) m_sub = wdata[1:0];
    if (we && addr == 5) m_base = {wdata[31:7], 7'd0};
    if (e_commit) begin stk_id.push_back(m_cand); stk_grp.push_back(m_cgrp); end
    if (e_pop) begin void'(stk_id.pop_back()); void'(stk_grp.pop_back()); end
    if (e_take || e_tail) begin
      m_ent = 1; m_cand = e_wid; m_cgrp = e_wg; m_cnt = EC - 1;
    end else if (m_ent) begin
      if (e_late) begin m_cand = e_wid; m_cgrp = e_wg; end
      if (e_commit) m_ent = 0; else m_cnt--;
    end
  endtask

  task automatic step(bit tk, bit eo, bit w, int a, logic [31:0] d);
    take = tk; eoi = eo; we = w; addr = RA'(a); wdata = d;
    #(CLK_P/2 - 1);
    compare();
    @(posedge clk);
    update();
    #1;
  endtask

  task automatic tick(bit tk = 0, bit eo = 0); step(tk, eo, 0, 0, 0); endtask
  task automatic wr(int a, logic [31:0] d); step(0, 0, 1, a, d); endtask
  task automatic idle(int n); repeat (n) tick(); endtask
  task automatic rd(int a); step(0, 0, 0, a, 0); endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_en[i] = 0; m_pend[i] = 0; m_prio[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R7 reset state: idle level, no offer
    idle(2);
    // R1 configuration: priorities, grouping S=1, enables except line 7
    wr(8, 0); wr(9, 2); wr(10, 5); wr(11, 6); wr(12, 6); wr(13, 4); wr(14, 6); wr(15, 7);
    for (int a = 8; a < 16; a++) rd(a);
    wr(4, 1); rd(4);
    wr(0, 32'hFF); wr(1, 32'h80); rd(0);
    // R5 basic entry of line 2
    irq[2] = 1; idle(2);
    tick(1); irq[2] = 0; idle(4);
    // R4 equal group does not preempt
    irq[5] = 1; idle(2); tick(1); irq[5] = 0; rd(2);
    // R6 late arrival during entry of line 1
    irq[1] = 1; idle(2); tick(1);
    irq[0] = 1; idle(5);
    irq[0] = 0; irq[1] = 0; idle(1);
    // R8 tail chain to line 1, then no chain to line 5, then return to idle
    tick(0, 1); idle(4);
    tick(0, 1); idle(2);
    tick(0, 1); idle(1);
    tick(1); idle(4);
    tick(0, 1); idle(2);
    // R9 eoi on empty stack ignored
    tick(0, 1); idle(1);
    // R3 tie break: lines 3, 6 prio 6 -> line 3 wins
    irq[3] = 1; irq[6] = 1; idle(2); tick(1); irq[3] = 0;
    want_id = 3; tick(); idle(3);
    // R9 eoi during entry ignored
    tick(0, 1); tick(0, 1); idle(1);
    tick(0, 1); idle(4); irq[6] = 0;
    while (m_ent || stk_grp.size() > 0) tick(0, !m_ent);
    idle(2);
    // R3 subpriority: line 3 prio 7, line 6 prio 6, same group -> line 6
    wr(11, 7); irq[3] = 1; irq[6] = 1; idle(2); tick(1); irq[6] = 0;
    want_id = 6; tick(); idle(3);
    // R2 line 6 request re-held, return -> pending again one cycle later
    irq[6] = 1; idle(1); tick(0, 1); rd(2); rd(2); irq[6] = 0; irq[3] = 0;
    while (m_ent || stk_grp.size() > 0) tick(m_ent ? 0 : preempt, !m_ent && !preempt);
    wr(3, 32'hFF); idle(1);
    // R5 base relocation
    wr(5, 32'h1000_00C4); rd(5);
    irq[7] = 1; idle(2);               // R3 disabled line never wins
    irq[7] = 0; wr(3, 32'h80);
    // R9 nest four levels with S=0, then a more urgent line meets a full stack
    wr(4, 0);
    irq[3] = 1; idle(2); tick(1); irq[3] = 0; idle(4);
    irq[2] = 1; idle(2); tick(1); irq[2] = 0; idle(4);
    irq[5] = 1; idle(2); tick(1); irq[5] = 0; idle(4);
    irq[1] = 1; idle(2); tick(1); irq[1] = 0; idle(4);
    irq[0] = 1; idle(3); tick(1); idle(2);
    irq[0] = 0;
    // R8 unwinding with line 0 pending chains from the full stack
    tick(0, 1); idle(4);
    while (m_ent || stk_grp.size() > 0) tick(0, !m_ent);
    idle(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule